// File: doc/BRIEF.md
# Three-Key Access Unlock Detector

This block guards a protected information region of an embedded flash. It sits behind one write-only register address. Software opens the region by writing three fixed 32-bit keys to that address, one after another and in a set order. When the third key lands, the block raises a registered access-grant signal. The flash array uses that signal to allow reads and writes of the region. While access is open, any write to the address closes it again. Reads of the address never reveal anything.

The detector only moves forward on write strobes, so software may leave idle cycles between key writes. A wrong value drops progress back to the start. The one exception is a wrong value that equals the first key, which counts as a fresh first step. Closing the region also clears all progress, so the full three-key sequence is needed to reopen it.

Top module: `info_access_unlock`

## Requirements
- R1: After synchronous reset, `grant` is 0 and the detector waits for the first key.
- R2: The keys are 0x3A7F5CA3 (first), 0xA1E34F20 (second) and 0x9608B2C1 (third). Writing them in that order sets `grant` to 1 on the clock edge that samples the third write.
- R3: `grant` never rises except on the edge that samples a write of the third key, directly preceded by the first and second keys in order.
- R4: While `grant` is 1, a write of any value, including any of the keys, clears `grant` on the edge that samples it.
- R5: The write that clears `grant` also clears all progress. Writing only the second and third keys afterwards does not grant access; a full three-key sequence does.
- R6: While access is closed, a written value that is neither the expected next key nor the first key returns the detector to its start state.
- R7: A written value equal to the first key always leaves the detector one step in (waiting for the second key), whatever step it was at before, unless access was open.
- R8: Cycles without a write strobe leave both progress and `grant` unchanged, however many there are.
- R9: `rd_data` is 0 in every cycle, whether access is open or closed, with or without a read strobe.
- R10: The read strobe has no effect on `grant` or on progress through the key sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the access register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe for the access register |
| rd_data | output | 32 | Read data, always zero |
| grant | output | 1 | Access to the protected region is open |

## Verification
The hardest state to reach from the ports is one where the detector is partway through the sequence and a wrong value arrives. Progress is invisible at the ports; only `grant` shows it, and only after a complete sequence. The bench therefore follows each disturbing write with a probe: a tail of the sequence (second then third key) that must not grant if progress was cleared, or that must grant if the disturbing write was the first key. Each probe ends with a cleanup write, so every scenario starts from a known idle state.

// File: rtl/info_access_unlock_pkg.sv
package info_access_unlock_pkg;

  localparam int unsigned KEY_W     = 32;
  localparam int unsigned KEY_COUNT = 3;

  // Ordered unlock keys; position in the order is behaviour.
  function automatic logic [KEY_W-1:0] key_at(input int unsigned idx);
    case (idx)
      0:       key_at = 32'h3A7F_5CA3;
      1:       key_at = 32'hA1E3_4F20;
      2:       key_at = 32'h9608_B2C1;
      default: key_at = '0;
    endcase
  endfunction

endpackage

// File: rtl/info_access_key_compare.sv
module info_access_key_compare
  import info_access_unlock_pkg::*;
#(
  parameter int unsigned DATA_W = KEY_W,
  parameter int unsigned N_KEYS = KEY_COUNT
) (
  input  logic [DATA_W-1:0] data,
  output logic [N_KEYS-1:0] hit
);

  // One equality comparator per key position.
  for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
    assign hit[g] = (data == key_at(g));
  end

endmodule

// File: rtl/info_access_step_ctrl.sv
module info_access_step_ctrl #(
  parameter int unsigned N_KEYS = 3,
  localparam int unsigned PW    = (N_KEYS > 1) ? $clog2(N_KEYS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [N_KEYS-1:0] hit,
  input  logic              open_q,
  output logic [PW-1:0]     prog_q,
  output logic              set_open,
  output logic              clr_open
);

  localparam logic [PW-1:0] LAST = PW'(N_KEYS - 1);

  logic [PW-1:0] prog_d;
  logic          hit_cur;

  assign hit_cur = hit[prog_q];

  always_comb begin
    prog_d   = prog_q;
    set_open = 1'b0;
    clr_open = 1'b0;
    if (wr_en) begin
      if (open_q) begin
        // any write while open closes and restarts
        clr_open = 1'b1;
        prog_d   = '0;
      end else if (hit_cur && prog_q == LAST) begin
        set_open = 1'b1;
        prog_d   = '0;
      end else if (hit_cur) begin
        prog_d = prog_q + PW'(1);
      end else if (hit[0]) begin
        prog_d = PW'(1);
      end else begin
        prog_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prog_q <= '0;
    else     prog_q <= prog_d;
  end

endmodule

// File: rtl/info_access_grant_reg.sv
module info_access_grant_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_open,
  input  logic              clr_open,
  output logic              open_q,
  output logic [DATA_W-1:0] rd_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (clr_open)      open_q <= 1'b0;
      else if (set_open) open_q <= 1'b1;
      rd_q <= '0;
    end
  end

endmodule

// File: rtl/info_access_unlock.sv
module info_access_unlock
  import info_access_unlock_pkg::*;
#(
  parameter int unsigned DATA_W = KEY_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              grant
);

  localparam int unsigned N_KEYS = KEY_COUNT;
  localparam int unsigned PROG_W = (N_KEYS > 1) ? $clog2(N_KEYS) : 1;

  logic [N_KEYS-1:0] hit;
  logic [PROG_W-1:0] prog_q;
  logic              set_open, clr_open, open_q;
  logic              unused_rd_en;

  // reads return zero, so the strobe is not consumed
  assign unused_rd_en = rd_en;

  info_access_key_compare #(.DATA_W(DATA_W), .N_KEYS(N_KEYS)) u_cmp (
    .data (wr_data),
    .hit  (hit)
  );

  info_access_step_ctrl #(.N_KEYS(N_KEYS)) u_step (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .hit      (hit),
    .open_q   (open_q),
    .prog_q   (prog_q),
    .set_open (set_open),
    .clr_open (clr_open)
  );

  info_access_grant_reg #(.DATA_W(DATA_W)) u_grant (
    .clk      (clk),
    .rst      (rst),
    .set_open (set_open),
    .clr_open (clr_open),
    .open_q   (open_q),
    .rd_q     (rd_data)
  );

  assign grant = open_q;

endmodule

// File: rtl/info_access_unlock_chk.sv
module info_access_unlock_chk
  import info_access_unlock_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              grant,
  input logic [PW-1:0]     prog
);

  localparam int unsigned LASTI = KEY_COUNT - 1;

  // R2
  a_r2_third_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !grant && prog == PW'(LASTI) && wr_data == key_at(LASTI)) |=> grant);

  // R3
  a_r3_open_only_by_third: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> ($past(wr_en) && $past(wr_data) == key_at(LASTI)
                      && $past(prog) == PW'(LASTI)));

  // R4 and R5
  a_r4_write_closes: assert property (@(posedge clk) disable iff (rst)
    (grant && wr_en) |=> (!grant && prog == '0));

  // R6
  a_r6_wrong_to_start: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !grant && wr_data != key_at(0) && wr_data != key_at(int'(prog)))
      |=> (prog == '0 && !grant));

  // R7
  a_r7_first_key_restarts: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !grant && wr_data == key_at(0)) |=> (prog == PW'(1)));

  // R8 and R10
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(grant) && $stable(prog)));

  // R9
  a_r9_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_data == '0));

endmodule

bind info_access_unlock info_access_unlock_chk #(.DATA_W(DATA_W), .PW(PROG_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .grant   (grant),
  .prog    (prog_q)
);

// File: tb/info_access_unlock_bench.sv
`timescale 1ns/1ps
module info_access_unlock_bench;

  localparam logic [31:0] K0  = 32'h3A7F_5CA3;
  localparam logic [31:0] K1  = 32'hA1E3_4F20;
  localparam logic [31:0] K2  = 32'h9608_B2C1;
  localparam logic [31:0] BAD = 32'h1234_5678;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        grant;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  info_access_unlock u_info_access_unlock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .grant(grant)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_grant(input bit exp, input string req);
    chk(grant == exp, req, {31'b0, grant}, {31'b0, exp});
  endtask

  // Drive one write at a falling edge; result is visible at the next falling edge.
  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Return to the closed start state from any state.
  task automatic to_start();
    wr(BAD);
    if (grant) wr(BAD);
  endtask

  task automatic t_reset();
    chk_grant(1'b0, "R1 grant low after reset");
    chk(rd_data == '0, "R1 rd_data after reset", rd_data, '0);
    wr(K1); wr(K2);
    chk_grant(1'b0, "R1 start state needs first key");
    to_start();
  endtask

  task automatic t_full();
    wr(K0); chk_grant(1'b0, "R2 after first key");
    wr(K1); chk_grant(1'b0, "R2 after second key");
    wr(K2); chk_grant(1'b1, "R2 after third key");
    to_start();
  endtask

  task automatic t_order();
    wr(K1); wr(K0); wr(K2);
    chk_grant(1'b0, "R3 swapped order");
    to_start();
    wr(K0); wr(K2); wr(K1);
    chk_grant(1'b0, "R3 second and third swapped");
    to_start();
    wr(K2); wr(K2); wr(K2);
    chk_grant(1'b0, "R3 repeated third key");
    to_start();
  endtask

  task automatic t_relock();
    logic [31:0] vals [4] = '{BAD, K0, K1, K2};
    foreach (vals[i]) begin
      wr(K0); wr(K1); wr(K2);
      chk_grant(1'b1, "R4 open before relock");
      wr(vals[i]);
      chk_grant(1'b0, "R4 any write closes");
    end
    to_start();
  endtask

  task automatic t_restart_after_relock();
    wr(K0); wr(K1); wr(K2);
    wr(K0);                          // closes; must not count as step one
    wr(K1); wr(K2);
    chk_grant(1'b0, "R5 relock write clears progress");
    to_start();
    wr(K0); wr(K1); wr(K2);
    wr(BAD);
    wr(K0); wr(K1); wr(K2);
    chk_grant(1'b1, "R5 full sequence reopens");
    to_start();
  endtask

  task automatic t_wrong_mid();
    wr(K0); wr(BAD); wr(K1); wr(K2);
    chk_grant(1'b0, "R6 wrong at step two");
    to_start();
    wr(K0); wr(K1); wr(BAD); wr(K1); wr(K2);
    chk_grant(1'b0, "R6 wrong at step three");
    to_start();
    wr(K0); wr(K1); wr(K1); wr(K2);
    chk_grant(1'b0, "R6 second key twice");
    to_start();
  endtask

  task automatic t_first_repeat();
    wr(K0); wr(K0); wr(K1); wr(K2);
    chk_grant(1'b1, "R7 first key twice");
    to_start();
    wr(K0); wr(K1); wr(K0); wr(K1); wr(K2);
    chk_grant(1'b1, "R7 first key at step three");
    to_start();
  endtask

  task automatic t_gaps();
    wr(K0); idle(7); wr(K1); idle(31); wr(K2);
    chk_grant(1'b1, "R8 gaps keep progress");
    idle(50);
    chk_grant(1'b1, "R8 grant holds without writes");
    to_start();
  endtask

  task automatic t_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk);
    chk(rd_data == '0, "R9 read while closed", rd_data, '0);
    rd_en = 1'b0;
    wr(K0); wr(K1); wr(K2);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk);
    chk(rd_data == '0, "R9 read while open", rd_data, '0);
    chk_grant(1'b1, "R10 read does not close");
    rd_en = 1'b0;
    to_start();
    wr(K0);
    @(negedge clk); rd_en = 1'b1; idle(3); rd_en = 1'b0;
    wr(K1); wr(K2);
    chk_grant(1'b1, "R10 read keeps progress");
    to_start();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_order();
    t_relock();
    t_restart_after_relock();
    t_wrong_mid();
    t_first_repeat();
    t_gaps();
    t_read();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

endmodule